// File: doc/BRIEF.md
# Multi-Engine Interrupt Status Aggregator

This block gathers the interrupt sources of a set of copy engines and folds them into one shared interrupt line. Each engine has three kinds of source: a copy-complete event, a group of watermark events and a group of error events. Every source sets a sticky status bit whenever it pulses, even when that source is disabled. Software clears a status bit by writing a one to it. A per-source enable decides whether a pending status bit counts towards the engine's summary bit. Copy-complete and watermark enables live in one register, and error enables live in a second register.

The summary vector has one bit per engine. Its bit is high while that engine has at least one enabled source pending, so a handler can scan it from engine 0 upward and service only the engines that need attention. The shared interrupt output is a registered OR of the summary vector. The highest-numbered engine is a polled diagnostic channel, and all of its enables come out of reset cleared.

Registers are reached through a simple word port. The address is the engine index concatenated with a 2-bit selector. The read data is combinational on the address, and writes take effect at the clock edge where the write strobe is high.

Top module: `irq_agg_top`

## Requirements
- R1: After reset all status bits are 0 and the interrupt output is low. Every engine except the last comes up with host enable = 1 (copy-complete only) and all error enables set. The last engine comes up with both enable registers 0.
- R2: A pulse on any event input sets its status bit at the next clock edge, whether or not that source is enabled. The bit then stays set until it is cleared. In the host status word, bit 0 is copy-complete and bits 1..NUM_WM are watermarks 0..NUM_WM-1. In the misc status word, bits 0..NUM_ERR-1 are errors.
- R3: A write to a status register (selector 2 = host status, 3 = misc status) clears exactly the bits that are one in the written data and leaves the others unchanged. Copy-complete and watermark bits can therefore be cleared independently.
- R4: If a source pulses in the same cycle as a write that clears its status bit, the bit is set after that edge.
- R5: summary_o[e] is high exactly when engine e has a status bit that is set and whose matching enable bit is set. It reflects the register state after each edge.
- R6: irq_o equals the OR of summary_o as it stood one clock earlier.
- R7: Enable registers (selector 0 = host enable, 1 = misc enable) take the written value and read it back. A write to an enable register changes no status bit.
- R8: Writing ones to a status register never sets a status bit.
- R9: Events on the last engine latch status after reset but raise neither its summary bit nor the interrupt output until software enables them.
- R10: A write addressed to engine e changes no register of any other engine. The address is {engine index, selector}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ENG_W+2 | Engine index in the upper bits, register selector in the low 2 bits |
| reg_wdata | input | WD | Write data (enable value or clear mask) |
| reg_rdata | output | WD | Read data of the addressed register, zero-extended |
| cc_evt_i | input | NUM_ENG | Copy-complete event pulse per engine |
| wm_evt_i | input | NUM_ENG*NUM_WM | Watermark event pulses, engine e at bits [e*NUM_WM +: NUM_WM] |
| err_evt_i | input | NUM_ENG*NUM_ERR | Error event pulses, engine e at bits [e*NUM_ERR +: NUM_ERR] |
| summary_o | output | NUM_ENG | Per-engine enabled-pending summary |
| irq_o | output | 1 | Registered shared interrupt |

## Verification
The bench builds the block with its default parameters: eight engines, four watermark sources and two error sources per engine. With these values the word port is five bits wide, so host registers and misc registers have different field widths. Engine 7 is the diagnostic channel with a distinct reset. This brings within reach partial clear masks that mix copy-complete and watermark bits, the collision of a clear with an event, and clears of the error bits while host bits are held. Long random runs of sparse events and register writes, checked against a bench model, also cover the enable-masking of many engines pending at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        SEL_HOST_EN  = 2'd0,
        SEL_MISC_EN  = 2'd1,
        SEL_HOST_STS = 2'd2,
        SEL_MISC_STS = 2'd3
    } reg_sel_e;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irq_agg_engine.sv
module irq_agg_engine
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_WM  = 4,
    parameter int unsigned NUM_ERR = 2,
    parameter int unsigned WD      = 5,
    parameter bit          IS_DIAG = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  reg_sel_e              wr_sel,
    input  logic [WD-1:0]         wdata,
    input  logic                  cc_evt,
    input  logic [NUM_WM-1:0]     wm_evt,
    input  logic [NUM_ERR-1:0]    err_evt,
    output logic [NUM_WM:0]       host_en_o,
    output logic [NUM_ERR-1:0]    misc_en_o,
    output logic [NUM_WM:0]       host_sts_o,
    output logic [NUM_ERR-1:0]    misc_sts_o,
    output logic                  pend_o
);
    localparam int unsigned HW = NUM_WM + 1;
    localparam logic [HW-1:0]      HOST_EN_RST = IS_DIAG ? '0 : HW'(1);
    localparam logic [NUM_ERR-1:0] MISC_EN_RST = IS_DIAG ? '0 : '1;

    logic [HW-1:0]      host_en_q, host_sts_q, host_evt, host_clr;
    logic [NUM_ERR-1:0] misc_en_q, misc_sts_q, misc_clr;

    assign host_evt = {wm_evt, cc_evt};
    assign host_clr = (wr_en && wr_sel == SEL_HOST_STS) ? wdata[HW-1:0] : '0;
    assign misc_clr = (wr_en && wr_sel == SEL_MISC_STS) ? wdata[NUM_ERR-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            host_en_q  <= HOST_EN_RST;
            misc_en_q  <= MISC_EN_RST;
            host_sts_q <= '0;
            misc_sts_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_HOST_EN) host_en_q <= wdata[HW-1:0];
            if (wr_en && wr_sel == SEL_MISC_EN) misc_en_q <= wdata[NUM_ERR-1:0];
            host_sts_q <= (host_sts_q & ~host_clr) | host_evt;
            misc_sts_q <= (misc_sts_q & ~misc_clr) | err_evt;
        end
    end

    assign pend_o     = (|(host_sts_q & host_en_q)) | (|(misc_sts_q & misc_en_q));
    assign host_en_o  = host_en_q;
    assign misc_en_o  = misc_en_q;
    assign host_sts_o = host_sts_q;
    assign misc_sts_o = misc_sts_q;

    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
        cc_evt |=> host_sts_q[0]);
    assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_HOST_STS && wdata[0] && !cc_evt) |=> !host_sts_q[0]);
    assert_sticky_sts_R2: assert property (@(posedge clk) disable iff (rst)
        (misc_sts_q[0] && !(wr_en && wr_sel == SEL_MISC_STS)) |=> misc_sts_q[0]);
    assert_no_set_by_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!host_sts_q[0] && !cc_evt) |=> !host_sts_q[0]);
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (host_en_q == '0 && misc_en_q == '0) |-> !pend_o);
endmodule

// File: rtl/irq_agg_summary.sv
module irq_agg_summary #(
    parameter int unsigned NUM_ENG = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ENG-1:0] summary_i,
    output logic               irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |summary_i;
    end

    assign irq_o = irq_q;

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (summary_i != '0) |=> irq_o);
    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (summary_i == '0) |=> !irq_o);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_ENG = 8,
    parameter int unsigned NUM_WM  = 4,
    parameter int unsigned NUM_ERR = 2,
    localparam int unsigned ENG_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
    localparam int unsigned HW     = NUM_WM + 1,
    localparam int unsigned WD     = imax(HW, NUM_ERR),
    localparam int unsigned ADDR_W = ENG_W + 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WD-1:0]               reg_wdata,
    output logic [WD-1:0]               reg_rdata,
    input  logic [NUM_ENG-1:0]          cc_evt_i,
    input  logic [NUM_ENG*NUM_WM-1:0]   wm_evt_i,
    input  logic [NUM_ENG*NUM_ERR-1:0]  err_evt_i,
    output logic [NUM_ENG-1:0]          summary_o,
    output logic                        irq_o
);
    logic [ENG_W-1:0] eng_idx;
    reg_sel_e         sel;

    assign eng_idx = reg_addr[ADDR_W-1:2];
    assign sel     = reg_sel_e'(reg_addr[1:0]);

    logic [HW-1:0]      host_en_a  [NUM_ENG];
    logic [HW-1:0]      host_sts_a [NUM_ENG];
    logic [NUM_ERR-1:0] misc_en_a  [NUM_ENG];
    logic [NUM_ERR-1:0] misc_sts_a [NUM_ENG];
    logic [NUM_ENG-1:0] pend;

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        logic hit;
        assign hit = reg_wr && (int'(eng_idx) == e);

        irq_agg_engine #(
            .NUM_WM (NUM_WM),
            .NUM_ERR(NUM_ERR),
            .WD     (WD),
            .IS_DIAG(e == NUM_ENG - 1)
        ) u_eng (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (hit),
            .wr_sel    (sel),
            .wdata     (reg_wdata),
            .cc_evt    (cc_evt_i[e]),
            .wm_evt    (wm_evt_i[e*NUM_WM +: NUM_WM]),
            .err_evt   (err_evt_i[e*NUM_ERR +: NUM_ERR]),
            .host_en_o (host_en_a[e]),
            .misc_en_o (misc_en_a[e]),
            .host_sts_o(host_sts_a[e]),
            .misc_sts_o(misc_sts_a[e]),
            .pend_o    (pend[e])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(eng_idx) < NUM_ENG) begin
            case (sel)
                SEL_HOST_EN:  reg_rdata = WD'(host_en_a[eng_idx]);
                SEL_MISC_EN:  reg_rdata = WD'(misc_en_a[eng_idx]);
                SEL_HOST_STS: reg_rdata = WD'(host_sts_a[eng_idx]);
                default:      reg_rdata = WD'(misc_sts_a[eng_idx]);
            endcase
        end
    end

    assign summary_o = pend;

    irq_agg_summary #(.NUM_ENG(NUM_ENG)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .summary_i(pend),
        .irq_o    (irq_o)
    );

    assert_diag_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (host_en_a[NUM_ENG-1] == '0 && misc_en_a[NUM_ENG-1] == '0) |-> !summary_o[NUM_ENG-1]);
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
    localparam int NE = 8, NW = 4, NR = 2, HW = NW + 1, WD = 5, AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [WD-1:0] reg_wdata = '0;
    logic [WD-1:0] reg_rdata;
    logic [NE-1:0] cc_evt = '0;
    logic [NE*NW-1:0] wm_evt = '0;
    logic [NE*NR-1:0] err_evt = '0;
    logic [NE-1:0] summary;
    logic irq;

    always #5 clk = ~clk;

    irq_agg_top u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cc_evt_i(cc_evt),
        .wm_evt_i(wm_evt), .err_evt_i(err_evt), .summary_o(summary), .irq_o(irq)
    );

    int checks = 0;
    int errors = 0;

    logic [HW-1:0] m_hen [NE];
    logic [HW-1:0] m_hst [NE];
    logic [NR-1:0] m_men [NE];
    logic [NR-1:0] m_mst [NE];
    logic m_irq;

    function automatic logic [NE-1:0] model_sum();
        logic [NE-1:0] s;
        for (int e = 0; e < NE; e++)
            s[e] = (|(m_hst[e] & m_hen[e])) | (|(m_mst[e] & m_men[e]));
        return s;
    endfunction

    function automatic logic [WD-1:0] model_rd(input logic [AW-1:0] a);
        int e = int'(a[AW-1:2]);
        case (a[1:0])
            2'd0: return WD'(m_hen[e]);
            2'd1: return WD'(m_men[e]);
            2'd2: return WD'(m_hst[e]);
            default: return WD'(m_mst[e]);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < NE; e++) begin
            m_hen[e] = (e == NE - 1) ? '0 : HW'(1);
            m_men[e] = (e == NE - 1) ? '0 : '1;
            m_hst[e] = '0;
            m_mst[e] = '0;
        end
        m_irq = 1'b0;
    endtask

    // One clock with the given stimulus; returns at the following negedge.
    task automatic step(input logic wr, input logic [AW-1:0] a, input logic [WD-1:0] d,
                        input logic [NE-1:0] cc, input logic [NE*NW-1:0] wm,
                        input logic [NE*NR-1:0] er);
        logic any_old;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        cc_evt = cc; wm_evt = wm; err_evt = er;
        @(posedge clk);
        any_old = |model_sum();
        for (int e = 0; e < NE; e++) begin
            logic [HW-1:0] hclr = '0;
            logic [NR-1:0] mclr = '0;
            if (wr && int'(a[AW-1:2]) == e) begin
                case (a[1:0])
                    2'd0: m_hen[e] = d[HW-1:0];
                    2'd1: m_men[e] = d[NR-1:0];
                    2'd2: hclr = d[HW-1:0];
                    default: mclr = d[NR-1:0];
                endcase
            end
            m_hst[e] = (m_hst[e] & ~hclr) | {wm[e*NW +: NW], cc[e]};
            m_mst[e] = (m_mst[e] & ~mclr) | er[e*NR +: NR];
        end
        m_irq = any_old;
        @(negedge clk);
        reg_wr = 1'b0; cc_evt = '0; wm_evt = '0; err_evt = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [WD-1:0] exp);
        reg_addr = a;
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic out_chk();
        chk("R5 summary", 32'(summary), 32'(model_sum()));
        chk("R6 irq", 32'(irq), 32'(m_irq));
    endtask

    function automatic logic [AW-1:0] ad(input int e, input int s);
        return AW'((e << 2) | s);
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd12345;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int e = 0; e < NE; e++) begin
            rd_chk("R1 host enable", ad(e, 0), (e == NE - 1) ? 5'd0 : 5'd1);
            rd_chk("R1 misc enable", ad(e, 1), (e == NE - 1) ? 5'd0 : 5'd3);
            rd_chk("R1 host status", ad(e, 2), 5'd0);
            rd_chk("R1 misc status", ad(e, 3), 5'd0);
        end
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 summary", 32'(summary), 32'd0);

        // R9 diagnostic engine: status latches, no summary
        step(0, '0, '0, NE'(1) << (NE - 1), '0, '0);
        rd_chk("R9 diag status", ad(NE - 1, 2), 5'd1);
        chk("R9 diag summary", 32'(summary[NE-1]), 32'd0);
        step(0, '0, '0, '0, '0, '0);
        chk("R9 diag irq", 32'(irq), 32'd0);

        // R2 disabled watermark latches on engine 2 (wm1 -> bit 2)
        step(0, '0, '0, '0, (NE*NW)'(1) << (2*NW + 1), '0);
        rd_chk("R2 wm status", ad(2, 2), 5'b00100);
        chk("R2 masked summary", 32'(summary[2]), 32'd0);

        // R7 enable write exposes it, status untouched
        step(1, ad(2, 0), 5'b00100, '0, '0, '0);
        rd_chk("R7 enable readback", ad(2, 0), 5'b00100);
        rd_chk("R7 status kept", ad(2, 2), 5'b00100);
        chk("R5 summary after enable", 32'(summary[2]), 32'd1);
        chk("R6 irq not yet", 32'(irq), 32'd0);
        step(0, '0, '0, '0, '0, '0);
        chk("R6 irq one cycle later", 32'(irq), 32'd1);

        // R3 clear cc alone, wm stays
        step(0, '0, '0, NE'(1) << 2, '0, '0);
        rd_chk("R2 cc status", ad(2, 2), 5'b00101);
        step(1, ad(2, 2), 5'b00001, '0, '0, '0);
        rd_chk("R3 partial clear", ad(2, 2), 5'b00100);
        step(1, ad(2, 2), 5'b00000, '0, '0, '0);
        rd_chk("R3 zero mask", ad(2, 2), 5'b00100);
        step(1, ad(2, 2), 5'b00100, '0, '0, '0);
        rd_chk("R3 wm cleared", ad(2, 2), 5'b00000);
        chk("R5 summary cleared", 32'(summary[2]), 32'd0);

        // R8 writing ones to clear status sets nothing
        step(1, ad(0, 2), 5'b11111, '0, '0, '0);
        rd_chk("R8 host no set", ad(0, 2), 5'd0);
        step(1, ad(0, 3), 5'b11111, '0, '0, '0);
        rd_chk("R8 misc no set", ad(0, 3), 5'd0);

        // R4 collision of clear and event
        step(0, '0, '0, NE'(1) << 3, '0, '0);
        step(1, ad(3, 2), 5'b00001, NE'(1) << 3, '0, '0);
        rd_chk("R4 event wins", ad(3, 2), 5'b00001);
        step(1, ad(3, 3), 5'b00011, '0, '0, (NE*NR)'(2) << (3*NR));
        rd_chk("R4 error event wins", ad(3, 3), 5'b00010);

        // R10 isolation
        step(1, ad(4, 0), 5'b11111, '0, '0, '0);
        rd_chk("R10 target written", ad(4, 0), 5'b11111);
        rd_chk("R10 neighbour above", ad(5, 0), 5'd1);
        rd_chk("R10 neighbour below", ad(3, 0), 5'd1);
        out_chk();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [NE-1:0] cc = '0;
            logic [NE*NW-1:0] wm = '0;
            logic [NE*NR-1:0] er = '0;
            logic wr;
            logic [AW-1:0] a;
            for (int b = 0; b < NE; b++)       cc[b] = ($urandom % 12) == 0;
            for (int b = 0; b < NE * NW; b++) wm[b] = ($urandom % 30) == 0;
            for (int b = 0; b < NE * NR; b++) er[b] = ($urandom % 40) == 0;
            wr = ($urandom % 3) == 0;
            a  = AW'($urandom);
            step(wr, a, WD'($urandom), cc, wm, er);
            out_chk();
            a = AW'($urandom);
            rd_chk((a[1] ? "R3 status random" : "R7 enable random"), a, model_rd(a));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule